// File: doc/BRIEF.md
# Biphase-Mark Packet Receiver

This block receives packets sent with biphase-mark coding on one of two configuration-channel wires. `line_sel_i` picks the wire. The chosen wire passes through a two-stage synchronizer.

One counter does two jobs:

- It measures the time between transitions, and the bit decoder uses that interval to recover bits.
- It declares the line idle once a programmable window of half-bits passes with no transition.

While the receiver hunts, recovered bits shift through a 20-bit window. The window is compared against three start sequences, and each sequence has its own enable bit.

Once a start sequence is accepted, the block groups the bits into 5-bit symbols. Each symbol maps to a nibble, and pairs of nibbles become bytes. A single-entry register with a valid/ready handshake delivers the bytes. An end symbol closes the message. A line that goes static, or an unknown symbol, also closes the message and reports an error.

The block sets sticky event flags, which are cleared by writing one to `clr_i`. A transmit request that arrives while the line is busy is refused and flagged, because traffic on the wire is half-duplex.

Top module: `bmc_pd_rx`

## Requirements
- R1: `active_o` goes high after a transition on the selected line. It goes low once no transition has been seen for (`win_hb_m1_i`+1)×`HBIT_CYC` clock cycles.
- R2: Only the line chosen by `line_sel_i` is decoded (0 = `line_a_i`, 1 = `line_b_i`). Activity on the other line has no effect on any output.
- R3: Bit decoding works on the interval between transitions. An interval of at least 1.5 half-bits gives a 0, and two shorter intervals in a row give a 1. The first transition after idle only starts timing.
- R4: Start sequences are written with the first-received bit leftmost. The symbols are A=11000, B=10001 and C=00110. Sequence type 0 is AAAB, type 1 is AACC and type 2 is ACAC. A sequence is accepted only when `os_en_i[type]` is 1. Acceptance sets `flags_o[0]` and puts the type on `os_type_o`.
- R5: Payload symbols map to nibbles as follows:
  - 0:11110, 1:01001, 2:10100, 3:10101
  - 4:01010, 5:01011, 6:01110, 7:01111
  - 8:10010, 9:10011, A:10110, B:10111
  - C:11010, D:11011, E:11100, F:11101
  
  The low nibble comes first. A byte stays on `byte_o` with `byte_valid_o` high until `byte_ready_i` takes it.
- R6: The end symbol 01101 sets `flags_o[1]`, and `pay_cnt_o` then holds the number of payload bytes received.
- R7: A line that goes static during the payload sets both `flags_o[1]` and `flags_o[2]`. An unknown symbol has the same effect.
- R8: If `crc_bad_i` is high when the end symbol is decoded, `flags_o[2]` is set.
- R9: A byte that completes while the previous byte has not been taken sets `flags_o[3]`. The new byte is dropped and the held byte stays unchanged. The new byte still counts in `pay_cnt_o`.
- R10: Every flag stays set until a 1 is written to the matching bit of `clr_i`. Clearing one flag leaves the others untouched.
- R11: A `tx_req_i` pulse while the line is active sets `flags_o[4]` and gives no `tx_go_o`. A pulse while the line is idle gives a one-cycle `tx_go_o` on the next cycle.
- R12: After reset, all flags, `byte_valid_o`, `active_o`, `tx_go_o` and `pay_cnt_o` are 0.
- R13: After a message ends, the receiver goes back to hunting, so messages sent one after another are each detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| line_sel_i | input | 1 | Selects the line to decode |
| line_a_i | input | 1 | Line A |
| line_b_i | input | 1 | Line B |
| win_hb_m1_i | input | WIN_W | Idle window in half-bits, minus one |
| os_en_i | input | 3 | Enable bit for each start-sequence type |
| crc_bad_i | input | 1 | Integrity failure reported by an outside checker |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | A byte is waiting on `byte_o` |
| byte_ready_i | input | 1 | The consumer takes the byte |
| os_type_o | output | 2 | Type of the last accepted start sequence |
| pay_cnt_o | output | CNT_W | Number of payload bytes in the current or last message |
| active_o | output | 1 | The line is non-idle |
| flags_o | output | 5 | Sticky flags: start, end, error, overrun, tx refused |
| clr_i | input | 5 | Write-one-to-clear for the flags |
| tx_req_i | input | 1 | Transmit request pulse |
| tx_go_o | output | 1 | Transmit is granted |

## Verification
A decoder that goes out of phase corrupts every later symbol. The error shows at the ports as a wrong byte or a missing start flag, about one frame after the fault.

A timing counter that is wrong moves the fall of `active_o` away from the programmed window. It also makes a truncated message finish with no error flag. The bench samples `active_o` inside the window and again after it.

A byte register or flag that holds a wrong state is seen directly. Examples are an overrun that overwrites the held byte, or a flag that clears on its own. The bench sees it at the end of the same frame or in the cycle after a clear write.

// File: rtl/bmc_pd_rx_pkg.sv
package bmc_pd_rx_pkg;
  localparam int NUM_OS = 3;
  localparam int OS_W   = 2;
  localparam int NUM_EV = 5;
  localparam int EV_OS  = 0;
  localparam int EV_END = 1;
  localparam int EV_ERR = 2;
  localparam int EV_OVR = 3;
  localparam int EV_TXD = 4;

  localparam logic [4:0] K_A   = 5'b11000;
  localparam logic [4:0] K_B   = 5'b10001;
  localparam logic [4:0] K_C   = 5'b00110;
  localparam logic [4:0] K_END = 5'b01101;

  typedef enum logic {FR_HUNT, FR_PAY} fr_state_e;

  function automatic logic [19:0] os_code(input int idx);
    case (idx)
      0:       return {K_A, K_A, K_A, K_B};
      1:       return {K_A, K_A, K_C, K_C};
      default: return {K_A, K_C, K_A, K_C};
    endcase
  endfunction

  // {valid, nibble}
  function automatic logic [4:0] sym_to_nib(input logic [4:0] s);
    case (s)
      5'b11110: return 5'h10;
      5'b01001: return 5'h11;
      5'b10100: return 5'h12;
      5'b10101: return 5'h13;
      5'b01010: return 5'h14;
      5'b01011: return 5'h15;
      5'b01110: return 5'h16;
      5'b01111: return 5'h17;
      5'b10010: return 5'h18;
      5'b10011: return 5'h19;
      5'b10110: return 5'h1A;
      5'b10111: return 5'h1B;
      5'b11010: return 5'h1C;
      5'b11011: return 5'h1D;
      5'b11100: return 5'h1E;
      5'b11101: return 5'h1F;
      default:  return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/bmc_rx_line.sv
module bmc_rx_line #(
  parameter int HBIT_CYC = 4,
  parameter int WIN_W    = 4,
  parameter int CW       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sel_i,
  input  logic             line_a_i,
  input  logic             line_b_i,
  input  logic [WIN_W-1:0] win_hb_m1_i,
  output logic             edge_o,
  output logic             first_o,
  output logic             static_o,
  output logic             active_o,
  output logic [CW-1:0]    intv_o
);
  localparam int MAX_CYC = (1 << WIN_W) * HBIT_CYC;

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] win_cyc;

  assign win_cyc  = CW'((int'(win_hb_m1_i) + 1) * HBIT_CYC);
  assign edge_o   = en_i && (sync_q[1] ^ lvl_q);
  assign active_o = cnt_q < win_cyc;
  assign first_o  = edge_o && !active_o;
  assign static_o = en_i && !edge_o && (cnt_q == win_cyc - CW'(1));
  assign intv_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], sel_i ? line_b_i : line_a_i};
      lvl_q  <= sync_q[1];
    end
  end

  // Time since the last transition; saturates to mark idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= CW'(MAX_CYC);
    else if (!en_i)                  cnt_q <= CW'(MAX_CYC);
    else if (edge_o)                 cnt_q <= CW'(1);
    else if (cnt_q < CW'(MAX_CYC))   cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/bmc_rx_bitdec.sv
module bmc_rx_bitdec #(
  parameter int HBIT_CYC = 4,
  parameter int CW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          first_i,
  input  logic          static_i,
  input  logic [CW-1:0] intv_i,
  output logic          bit_vld_o,
  output logic          bit_o
);
  localparam int THR = (3 * HBIT_CYC) / 2;

  logic half_q;
  logic long_iv;

  assign long_iv = intv_i >= CW'(THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q    <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (static_i || first_i) begin
        half_q <= 1'b0;
      end else if (edge_i) begin
        if (long_iv) begin
          bit_vld_o <= 1'b1;
          bit_o     <= 1'b0;
          half_q    <= 1'b0;
        end else if (half_q) begin
          bit_vld_o <= 1'b1;
          bit_o     <= 1'b1;
          half_q    <= 1'b0;
        end else begin
          half_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bmc_rx_frame.sv
module bmc_rx_frame
  import bmc_pd_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              static_i,
  input  logic [NUM_OS-1:0] os_en_i,
  input  logic              crc_bad_i,
  input  logic              byte_ready_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  output logic [OS_W-1:0]   os_type_o,
  output logic [CNT_W-1:0]  pay_cnt_o,
  output logic              in_msg_o,
  output logic              ev_os_o,
  output logic              ev_end_o,
  output logic              ev_err_o,
  output logic              ev_ovr_o
);
  fr_state_e         st_q;
  logic [19:0]       sr_q;
  logic [19:0]       sr_nx;
  logic [NUM_OS-1:0] hit;
  logic [OS_W-1:0]   hit_idx;
  logic [3:0]        sym_q;
  logic [4:0]        sym_nx;
  logic [2:0]        sym_cnt_q;
  logic [4:0]        dec;
  logic [3:0]        nib_lo_q;
  logic              nib_half_q;

  assign sr_nx    = {sr_q[18:0], bit_i};
  assign sym_nx   = {sym_q, bit_i};
  assign dec      = sym_to_nib(sym_nx);
  assign in_msg_o = (st_q == FR_PAY);

  for (genvar g = 0; g < NUM_OS; g++) begin : g_os
    assign hit[g] = os_en_i[g] && (sr_nx == os_code(g));
  end

  // lowest enabled type wins
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_OS - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = OS_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= FR_HUNT;
      sr_q         <= '0;
      sym_q        <= '0;
      sym_cnt_q    <= '0;
      nib_lo_q     <= '0;
      nib_half_q   <= 1'b0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      os_type_o    <= '0;
      pay_cnt_o    <= '0;
      ev_os_o      <= 1'b0;
      ev_end_o     <= 1'b0;
      ev_err_o     <= 1'b0;
      ev_ovr_o     <= 1'b0;
    end else begin
      ev_os_o  <= 1'b0;
      ev_end_o <= 1'b0;
      ev_err_o <= 1'b0;
      ev_ovr_o <= 1'b0;
      if (byte_valid_o && byte_ready_i) byte_valid_o <= 1'b0;
      if (!en_i) begin
        st_q <= FR_HUNT;
        sr_q <= '0;
      end else begin
        case (st_q)
          FR_HUNT: begin
            if (static_i) begin
              sr_q <= '0;
            end else if (bit_vld_i) begin
              sr_q <= sr_nx;
              if (|hit) begin
                st_q       <= FR_PAY;
                sr_q       <= '0;
                os_type_o  <= hit_idx;
                ev_os_o    <= 1'b1;
                pay_cnt_o  <= '0;
                sym_cnt_q  <= '0;
                nib_half_q <= 1'b0;
              end
            end
          end
          default: begin
            if (static_i) begin
              ev_end_o <= 1'b1;
              ev_err_o <= 1'b1;
              st_q     <= FR_HUNT;
            end else if (bit_vld_i) begin
              if (sym_cnt_q == 3'd4) begin
                sym_cnt_q <= '0;
                if (sym_nx == K_END) begin
                  ev_end_o <= 1'b1;
                  ev_err_o <= crc_bad_i;
                  st_q     <= FR_HUNT;
                end else if (!dec[4]) begin
                  ev_end_o <= 1'b1;
                  ev_err_o <= 1'b1;
                  st_q     <= FR_HUNT;
                end else if (!nib_half_q) begin
                  nib_lo_q   <= dec[3:0];
                  nib_half_q <= 1'b1;
                end else begin
                  nib_half_q <= 1'b0;
                  pay_cnt_o  <= pay_cnt_o + CNT_W'(1);
                  if (byte_valid_o && !byte_ready_i) begin
                    ev_ovr_o <= 1'b1;
                  end else begin
                    byte_o       <= {dec[3:0], nib_lo_q};
                    byte_valid_o <= 1'b1;
                  end
                end
              end else begin
                sym_q     <= sym_nx[3:0];
                sym_cnt_q <= sym_cnt_q + 3'd1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bmc_pd_rx.sv
module bmc_pd_rx
  import bmc_pd_rx_pkg::*;
#(
  parameter int HBIT_CYC = 4,
  parameter int WIN_W    = 4,
  parameter int CNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              line_sel_i,
  input  logic              line_a_i,
  input  logic              line_b_i,
  input  logic [WIN_W-1:0]  win_hb_m1_i,
  input  logic [NUM_OS-1:0] os_en_i,
  input  logic              crc_bad_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [OS_W-1:0]   os_type_o,
  output logic [CNT_W-1:0]  pay_cnt_o,
  output logic              active_o,
  output logic [NUM_EV-1:0] flags_o,
  input  logic [NUM_EV-1:0] clr_i,
  input  logic              tx_req_i,
  output logic              tx_go_o
);
  localparam int MAX_CYC = (1 << WIN_W) * HBIT_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          edge_w, first_w, static_w;
  logic [CW-1:0] intv_w;
  logic          bit_vld_w, bit_w;
  logic          in_msg_w, busy_w;
  logic          ev_os_w, ev_end_w, ev_err_w, ev_ovr_w;
  logic [NUM_EV-1:0] ev_w;
  logic [NUM_EV-1:0] flags_q;

  bmc_rx_line #(.HBIT_CYC(HBIT_CYC), .WIN_W(WIN_W), .CW(CW)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .sel_i(line_sel_i),
    .line_a_i(line_a_i), .line_b_i(line_b_i), .win_hb_m1_i(win_hb_m1_i),
    .edge_o(edge_w), .first_o(first_w), .static_o(static_w),
    .active_o(active_o), .intv_o(intv_w)
  );

  bmc_rx_bitdec #(.HBIT_CYC(HBIT_CYC), .CW(CW)) u_bitdec (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w), .first_i(first_w),
    .static_i(static_w), .intv_i(intv_w), .bit_vld_o(bit_vld_w), .bit_o(bit_w)
  );

  bmc_rx_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .bit_vld_i(bit_vld_w),
    .bit_i(bit_w), .static_i(static_w), .os_en_i(os_en_i), .crc_bad_i(crc_bad_i),
    .byte_ready_i(byte_ready_i), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .os_type_o(os_type_o), .pay_cnt_o(pay_cnt_o), .in_msg_o(in_msg_w),
    .ev_os_o(ev_os_w), .ev_end_o(ev_end_w), .ev_err_o(ev_err_w), .ev_ovr_o(ev_ovr_w)
  );

  assign busy_w = active_o | in_msg_w;

  always_comb begin
    ev_w         = '0;
    ev_w[EV_OS]  = ev_os_w;
    ev_w[EV_END] = ev_end_w;
    ev_w[EV_ERR] = ev_err_w;
    ev_w[EV_OVR] = ev_ovr_w;
    ev_w[EV_TXD] = tx_req_i & busy_w;
  end

  // set wins over clear
  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[g] <= 1'b0;
      else         flags_q[g] <= ev_w[g] | (flags_q[g] & ~clr_i[g]);
    end
  end
  assign flags_o = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_go_o <= 1'b0;
    else         tx_go_o <= tx_req_i & ~busy_w;
  end
endmodule

// File: rtl/bmc_pd_rx_chk.sv
module bmc_pd_rx_chk
  import bmc_pd_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        byte_o,
  input logic              byte_valid_o,
  input logic              byte_ready_i,
  input logic [NUM_OS-1:0] os_en_i,
  input logic [OS_W-1:0]   os_type_o,
  input logic [NUM_EV-1:0] flags_o,
  input logic [NUM_EV-1:0] clr_i,
  input logic              tx_req_i,
  input logic              tx_go_o,
  input logic              active_o
);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o));

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(flags_o & ~clr_i) |=> ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i)));

  p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[EV_OS]) |-> ((os_en_i >> os_type_o) & 3'b001) != 3'b000);

  p_go_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_go_o |-> $past(tx_req_i) && !$past(active_o));

  p_refuse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i && active_o |=> flags_o[EV_TXD] && !tx_go_o);
endmodule

bind bmc_pd_rx bmc_pd_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
  .byte_ready_i(byte_ready_i), .os_en_i(os_en_i), .os_type_o(os_type_o),
  .flags_o(flags_o), .clr_i(clr_i), .tx_req_i(tx_req_i), .tx_go_o(tx_go_o),
  .active_o(active_o)
);

// File: tb/bmc_pd_rx_tb.sv
`timescale 1ns/1ps
module bmc_pd_rx_tb_top;
  localparam int HB = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en = 1'b1;
  logic       sel = 1'b0;
  logic       la = 1'b0, lb = 1'b0;
  logic [3:0] win = 4'd7;
  logic [2:0] os_en = 3'b111;
  logic       crc_bad = 1'b0;
  logic [7:0] byte_w;
  logic       bvalid;
  logic       bready = 1'b1;
  logic [1:0] os_type;
  logic [7:0] pay_cnt;
  logic       active;
  logic [4:0] flags;
  logic [4:0] clr = '0;
  logic       tx_req = 1'b0;
  logic       tx_go;

  int n_chk = 0, n_fail = 0, ncap = 0;
  logic [7:0] cap [8];

  always #4 clk_i = ~clk_i;

  bmc_pd_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en), .line_sel_i(sel),
    .line_a_i(la), .line_b_i(lb), .win_hb_m1_i(win), .os_en_i(os_en),
    .crc_bad_i(crc_bad), .byte_o(byte_w), .byte_valid_o(bvalid),
    .byte_ready_i(bready), .os_type_o(os_type), .pay_cnt_o(pay_cnt),
    .active_o(active), .flags_o(flags), .clr_i(clr), .tx_req_i(tx_req),
    .tx_go_o(tx_go)
  );

  always @(negedge clk_i) begin
    if (bvalid && bready && ncap < 8) begin
      cap[ncap] = byte_w;
      ncap = ncap + 1;
    end
  end

  typedef struct packed {
    logic        sel;
    logic [2:0]  mask;
    logic [1:0]  os;
    logic [2:0]  n;
    logic        trunc;
    logic        crc;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 3'b111, 2'd0, 3'd2, 1'b0, 1'b0, 32'h0000_5AA5},
    '{1'b1, 3'b111, 2'd1, 3'd4, 1'b0, 1'b0, 32'h1234_5678},
    '{1'b0, 3'b010, 2'd2, 3'd1, 1'b0, 1'b0, 32'h0000_005A},
    '{1'b0, 3'b100, 2'd2, 3'd1, 1'b0, 1'b0, 32'h0000_00FF},
    '{1'b1, 3'b001, 2'd0, 3'd3, 1'b1, 1'b0, 32'h001A_2B3C},
    '{1'b0, 3'b111, 2'd0, 3'd0, 1'b0, 1'b1, 32'h0000_0000},
    '{1'b0, 3'b111, 2'd1, 3'd1, 1'b0, 1'b0, 32'h0000_00C0}
  };

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100;
      4'h3: return 5'b10101; 4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111; 4'h8: return 5'b10010;
      4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [19:0] os_bits(input int k);
    case (k)
      0: return {5'b11000, 5'b11000, 5'b11000, 5'b10001};
      1: return {5'b11000, 5'b11000, 5'b00110, 5'b00110};
      default: return {5'b11000, 5'b00110, 5'b11000, 5'b00110};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hb();
    repeat (HB) @(negedge clk_i);
  endtask

  task automatic tog(input logic w);
    if (w) lb = ~lb; else la = ~la;
  endtask

  task automatic send_bit(input logic w, input logic b);
    tog(w); hb();
    if (b) tog(w);
    hb();
  endtask

  task automatic send_sym(input logic w, input logic [4:0] s);
    for (int i = 4; i >= 0; i--) send_bit(w, s[i]);
  endtask

  task automatic send_frame(input logic w, input int os, input int n,
                            input logic [31:0] d, input logic trunc);
    logic [19:0] o;
    o = os_bits(os);
    for (int i = 0; i < 16; i++) send_bit(w, i[0]);
    for (int i = 19; i >= 0; i--) send_bit(w, o[i]);
    for (int i = 0; i < n; i++) begin
      send_sym(w, enc(d[8*i +: 4]));
      send_sym(w, enc(d[8*i+4 +: 4]));
    end
    if (!trunc) send_sym(w, 5'b01101);
    tog(w);
    repeat (80) @(negedge clk_i);
  endtask

  task automatic clear_all();
    @(negedge clk_i); clr = 5'h1F;
    @(negedge clk_i); clr = 5'h00;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 flags", 32'(flags), 0);
    chk("R12 valid", 32'(bvalid), 0);
    chk("R12 active", 32'(active), 0);
    chk("R12 tx_go", 32'(tx_go), 0);
    chk("R12 count", 32'(pay_cnt), 0);

    // table walk: R3 R4 R5 R6 R7 R8 R13
    for (int v = 0; v < 7; v++) begin
      vec_t t;
      logic det;
      t = VECS[v];
      det = t.mask[t.os];
      sel = t.sel; os_en = t.mask; crc_bad = t.crc;
      repeat (60) @(negedge clk_i);
      clear_all();
      ncap = 0;
      send_frame(t.sel, int'(t.os), int'(t.n), t.data, t.trunc);
      chk("R4 R6 R7 R8 flags", 32'(flags),
          32'({1'b0, 1'b0, det & (t.trunc | t.crc), det, det}));
      if (det) begin
        chk("R4 type", 32'(os_type), 32'(t.os));
        chk("R6 count", 32'(pay_cnt), 32'(t.n));
      end
      chk("R5 R13 nbytes", 32'(ncap), det ? 32'(t.n) : 0);
      for (int i = 0; i < 8; i++)
        if (det && i < int'(t.n)) chk("R3 R5 byte", 32'(cap[i]), 32'(t.data[8*i +: 8]));
    end

    // R2: frame on unselected line ignored
    sel = 1'b0; os_en = 3'b111; crc_bad = 1'b0;
    repeat (60) @(negedge clk_i);
    clear_all(); ncap = 0;
    send_frame(1'b1, 0, 1, 32'h77, 1'b0);
    chk("R2 flags", 32'(flags), 0);
    chk("R2 bytes", 32'(ncap), 0);
    chk("R2 active", 32'(active), 0);

    // R1 window, 8 half-bits = 32 cycles
    win = 4'd7;
    tog(1'b0);
    repeat (20) @(negedge clk_i);
    chk("R1 active in window", 32'(active), 1);
    repeat (20) @(negedge clk_i);
    chk("R1 idle after window", 32'(active), 0);
    win = 4'd15;
    tog(1'b0);
    repeat (40) @(negedge clk_i);
    chk("R1 active long window", 32'(active), 1);
    repeat (40) @(negedge clk_i);
    chk("R1 idle long window", 32'(active), 0);
    chk("R1 no flags", 32'(flags), 0);
    win = 4'd7;

    // R11 grant while idle
    @(negedge clk_i); tx_req = 1'b1;
    @(negedge clk_i); tx_req = 1'b0;
    chk("R11 go", 32'(tx_go), 1);
    chk("R11 no refuse", 32'(flags[4]), 0);
    @(negedge clk_i);
    chk("R11 go one cycle", 32'(tx_go), 0);

    // R11 refuse while busy
    clear_all(); ncap = 0;
    fork
      send_frame(1'b0, 0, 1, 32'h3C, 1'b0);
      begin
        repeat (200) @(negedge clk_i);
        tx_req = 1'b1;
        @(negedge clk_i); tx_req = 1'b0;
        chk("R11 busy no go", 32'(tx_go), 0);
        chk("R11 refuse flag", 32'(flags[4]), 1);
      end
    join

    // R9 overrun with consumer stalled
    clear_all(); ncap = 0;
    bready = 1'b0;
    send_frame(1'b0, 0, 2, 32'h2211, 1'b0);
    chk("R9 ovr flag", 32'(flags[3]), 1);
    chk("R9 held byte", 32'(byte_w), 32'h11);
    chk("R9 valid", 32'(bvalid), 1);
    chk("R9 count", 32'(pay_cnt), 2);

    // R10 selective clear
    @(negedge clk_i); clr = 5'b01000;
    @(negedge clk_i); clr = 5'b00000;
    chk("R10 cleared", 32'(flags[3]), 0);
    chk("R10 others kept", 32'(flags[1:0]), 32'h3);
    repeat (5) @(negedge clk_i);
    chk("R10 sticky", 32'(flags[1:0]), 32'h3);
    bready = 1'b1;
    @(negedge clk_i);
    chk("R5 taken", 32'(bvalid), 0);

    summary();
  end
endmodule